// File: doc/BRIEF.md
# Fault Supervisor with Enable-Timed Reset

This block sits between the digital outputs of a bridge driver's analog monitors and the gate drive logic. It takes seven fault indications: over-temperature, supply over-voltage, over-current, regulator under-voltage, supply undervoltage lockout, an open protection-level pin, and a short-circuit detect. Each raw comparator input passes through its own debounce counter. The block then sorts the filtered flags into three groups. Warnings only pull the error line low. Shutdown faults also force every gate output off and clear by themselves. The short-circuit error is held until the enable input resets it.

The enable input is decoded in time. A short low pulse leaves the error registers untouched. A longer low interval clears them. A very long low interval requests sleep. After the enable rises again, an arming delay passes before the error logic and the gate outputs become active. Leaving sleep uses a longer wake delay instead. Every interval is a clock-cycle count set by a parameter.

A 3-bit code names the highest-priority active cause. The state machine has six states:
- SLEEP, left for WAKE when enable is high.
- WAKE, which returns to SLEEP if enable drops and moves to RUN after the wake delay.
- ARM, which moves to ENLOW if enable drops and to RUN after the arming delay.
- RUN, which moves to ENLOW if enable drops and to LOCK on a filtered lockout.
- LOCK, which moves to ENLOW when enable drops.
- ENLOW, which moves to ARM when enable rises and to SLEEP after the sleep delay.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is asserted the outputs are: sleep_req=1, gate_off=1, err_n=0 and fault_code=0.
- R2: From sleep, the first clock edge that samples en_in high drops sleep_req. The block enters normal running WAKE_CYC edges after that first edge. Until then err_n stays 0 and gate_off stays 1.
- R3: A raw fault input raises its filtered flag only on the Nth consecutive clock edge that samples it high, where N is that input's debounce parameter. A shorter high run has no effect on the outputs. The flag drops on the first edge that samples the input low.
- R4: Over-voltage, over-temperature and over-current are warnings. While running, each drives err_n=0 and keeps gate_off=0. Their codes are 5, 6 and 7 respectively. Each clears by itself when its input goes low.
- R5: Regulator under-voltage (code 4) and an open protection-level pin (code 3) drive err_n=0 and gate_off=1 while running. Both clear by themselves.
- R6: A short-circuit detect seen while running is latched. It gives code 2, err_n=0 and gate_off=1, and it stays latched after sc_det returns low.
- R7: The first clock edge that samples en_in low puts err_n=0 and gate_off=1.
- R8: If en_in is sampled low on at most RST_MIN_CYC consecutive edges, the short-circuit latch is kept. If it is sampled low on more than RST_MIN_CYC edges, the latch is cleared.
- R9: After en_in rises following an enable-low interval, err_n=0 and gate_off=1 are held for ARM_CYC edges. The block then resumes running.
- R10: If en_in is sampled low on more than SLEEP_CYC consecutive edges, sleep_req=1. While sleep_req=1, gate_off=1 and err_n=0.
- R11: A filtered supply lockout while running gives code 1 and then enters lockout, with sleep_req=1 and gate_off=1. Lockout persists after the lockout input clears. Only an enable low followed by high restarts the block.
- R12: fault_code follows the order lockout(1) > short(2) > open pin(3) > regulator UV(4) > over-voltage(5) > over-temperature(6) > over-current(7), with 0 when no cause is active.
- R13: While running, err_n is 1 exactly when fault_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Synchronized enable, high to operate |
| ot_raw | input | 1 | Over-temperature comparator |
| ov_raw | input | 1 | Supply over-voltage comparator |
| oc_raw | input | 1 | Over-current comparator |
| vreg_uv_raw | input | 1 | Regulator under-voltage comparator |
| vs_uv_raw | input | 1 | Supply undervoltage lockout comparator |
| lvl_open_raw | input | 1 | Protection-level pin open detector |
| sc_det | input | 1 | Filtered short-circuit detect |
| err_n | output | 1 | Active-low error indication |
| gate_off | output | 1 | Forces all gate outputs off |
| sleep_req | output | 1 | Requests low-power sleep |
| fault_code | output | 3 | Highest-priority active cause |

## Verification
The bench probes the enable-low interval right at RST_MIN_CYC edges and at one edge more. A design that compared its counter one cycle off would either clear the short latch on a tolerated glitch or keep it after a real reset. The debounce, arming, wake and sleep windows are each sampled one edge before their boundary and at the boundary, which exposes off-by-one counters. Random combinations of simultaneous faults check the priority code and the gate_off split between warnings and shutdowns. Directed cases check that lockout survives the removal of its cause and that a short latch outranks an open pin.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_WAKE  = 3'd1,
        ST_ARM   = 3'd2,
        ST_RUN   = 3'd3,
        ST_ENLOW = 3'd4,
        ST_LOCK  = 3'd5
    } fsup_state_t;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_UVLO  = 3'd1,
        FC_SHORT = 3'd2,
        FC_OPEN  = 3'd3,
        FC_VREG  = 3'd4,
        FC_OVERV = 3'd5,
        FC_OVERT = 3'd6,
        FC_OVERI = 3'd7
    } fsup_code_t;

    // index of each comparator inside the filter bank
    localparam int unsigned IX_OV   = 0;
    localparam int unsigned IX_UVLO = 1;
    localparam int unsigned IX_VREG = 2;
    localparam int unsigned IX_OC   = 3;
    localparam int unsigned IX_OPEN = 4;
    localparam int unsigned IX_OT   = 5;
    localparam int unsigned N_FILT  = 6;

endpackage

// File: rtl/fsup_filter.sv
module fsup_filter #(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flt
);
    localparam int unsigned CW = (N < 2) ? 1 : $clog2(N);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flt     <= 1'b0;
        end else if (!raw) begin
            run_cnt <= '0;
            flt     <= 1'b0;
        end else if (run_cnt < CW'(N - 1)) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            flt <= 1'b1;
        end
    end

endmodule

// File: rtl/fsup_prio.sv
module fsup_prio
    import fsup_pkg::*;
(
    input  logic       uvlo,
    input  logic       short_err,
    input  logic       open_pin,
    input  logic       vreg_uv,
    input  logic       over_v,
    input  logic       over_t,
    input  logic       over_i,
    output fsup_code_t code
);
    always_comb begin
        if (uvlo)           code = FC_UVLO;
        else if (short_err) code = FC_SHORT;
        else if (open_pin)  code = FC_OPEN;
        else if (vreg_uv)   code = FC_VREG;
        else if (over_v)    code = FC_OVERV;
        else if (over_t)    code = FC_OVERT;
        else if (over_i)    code = FC_OVERI;
        else                code = FC_NONE;
    end

endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
    import fsup_pkg::*;
#(
    parameter int unsigned RST_MIN_CYC = 240,
    parameter int unsigned ARM_CYC     = 1150,
    parameter int unsigned SLEEP_CYC   = 83000,
    parameter int unsigned WAKE_CYC    = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        uvlo,
    output fsup_state_t state,
    output logic        clr_short
);
    localparam int unsigned M1  = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int unsigned M2  = (ARM_CYC > RST_MIN_CYC) ? ARM_CYC : RST_MIN_CYC;
    localparam int unsigned MX  = (M1 > M2) ? M1 : M2;
    localparam int unsigned CW  = $clog2(MX + 1);

    fsup_state_t   state_nx;
    logic [CW-1:0] cnt;

    // state register and interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SLEEP;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state)   cnt <= '0;
            else if (cnt != CW'(MX)) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP: if (en) state_nx = ST_WAKE;
            ST_WAKE: begin
                if (!en)                          state_nx = ST_SLEEP;
                else if (cnt == CW'(WAKE_CYC - 1)) state_nx = ST_RUN;
            end
            ST_ARM: begin
                if (!en)                          state_nx = ST_ENLOW;
                else if (cnt == CW'(ARM_CYC - 1))  state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!en)       state_nx = ST_ENLOW;
                else if (uvlo) state_nx = ST_LOCK;
            end
            ST_LOCK: if (!en) state_nx = ST_ENLOW;
            ST_ENLOW: begin
                if (en)                              state_nx = ST_ARM;
                else if (cnt == CW'(SLEEP_CYC - 1))  state_nx = ST_SLEEP;
            end
            default: state_nx = ST_SLEEP;
        endcase
    end

    // reset of the error registers once the low interval exceeds the minimum
    always_comb begin
        clr_short = (state == ST_ENLOW) && (cnt == CW'(RST_MIN_CYC));
    end

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned DB_OV_CYC   = 3800,
    parameter int unsigned DB_UVLO_CYC = 4000,
    parameter int unsigned DB_VREG_CYC = 4000,
    parameter int unsigned DB_OC_CYC   = 660,
    parameter int unsigned DB_OPEN_CYC = 500,
    parameter int unsigned DB_OT_CYC   = 20,
    parameter int unsigned RST_MIN_CYC = 240,
    parameter int unsigned ARM_CYC     = 1150,
    parameter int unsigned SLEEP_CYC   = 83000,
    parameter int unsigned WAKE_CYC    = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_in,
    input  logic       ot_raw,
    input  logic       ov_raw,
    input  logic       oc_raw,
    input  logic       vreg_uv_raw,
    input  logic       vs_uv_raw,
    input  logic       lvl_open_raw,
    input  logic       sc_det,
    output logic       err_n,
    output logic       gate_off,
    output logic       sleep_req,
    output logic [2:0] fault_code
);
    localparam int unsigned DB_TAB [N_FILT] =
        '{DB_OV_CYC, DB_UVLO_CYC, DB_VREG_CYC, DB_OC_CYC, DB_OPEN_CYC, DB_OT_CYC};

    logic [N_FILT-1:0] raw_vec;
    logic [N_FILT-1:0] flt_vec;
    fsup_state_t       state;
    logic              clr_short;
    logic              short_q;
    fsup_code_t        enc;
    logic              running;

    always_comb begin
        raw_vec          = '0;
        raw_vec[IX_OV]   = ov_raw;
        raw_vec[IX_UVLO] = vs_uv_raw;
        raw_vec[IX_VREG] = vreg_uv_raw;
        raw_vec[IX_OC]   = oc_raw;
        raw_vec[IX_OPEN] = lvl_open_raw;
        raw_vec[IX_OT]   = ot_raw;
    end

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        fsup_filter #(.N(DB_TAB[g])) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_vec[g]),
            .flt   (flt_vec[g])
        );
    end

    fsup_ctrl #(
        .RST_MIN_CYC (RST_MIN_CYC),
        .ARM_CYC     (ARM_CYC),
        .SLEEP_CYC   (SLEEP_CYC),
        .WAKE_CYC    (WAKE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_in),
        .uvlo      (flt_vec[IX_UVLO]),
        .state     (state),
        .clr_short (clr_short)
    );

    // short-circuit latch: armed only while running, cleared by enable reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              short_q <= 1'b0;
        else if (clr_short)                      short_q <= 1'b0;
        else if (sc_det && (state == ST_RUN))    short_q <= 1'b1;
    end

    fsup_prio u_prio (
        .uvlo      (flt_vec[IX_UVLO]),
        .short_err (short_q),
        .open_pin  (flt_vec[IX_OPEN]),
        .vreg_uv   (flt_vec[IX_VREG]),
        .over_v    (flt_vec[IX_OV]),
        .over_t    (flt_vec[IX_OT]),
        .over_i    (flt_vec[IX_OC]),
        .code      (enc)
    );

    // outputs decoded from the state
    always_comb begin
        running    = (state == ST_RUN);
        sleep_req  = (state == ST_SLEEP) || (state == ST_LOCK);
        err_n      = running && (enc == FC_NONE);
        gate_off   = !running || short_q || flt_vec[IX_OPEN]
                     || flt_vec[IX_VREG] || flt_vec[IX_UVLO];
        if (running)                fault_code = enc;
        else if (state == ST_LOCK)  fault_code = FC_UVLO;
        else                        fault_code = FC_NONE;
    end

endmodule

// File: rtl/fault_supervisor_sva.sv
module fault_supervisor_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       en_in,
    input logic       err_n,
    input logic       gate_off,
    input logic       sleep_req,
    input logic [2:0] fault_code
);
    a_r7_enable_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> (!err_n && gate_off));

    a_r13_err_high_no_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_n |-> (fault_code == 3'd0));

    a_r13_code_pulls_err: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0) |-> !err_n);

    a_r4_warning_keeps_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code >= 3'd5) |-> !gate_off);

    a_r5_shutdown_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code >= 3'd2) && (fault_code <= 3'd4)) |-> gate_off);

    a_r6_short_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code == 3'd2) && en_in) |=> ((fault_code == 3'd2) || (fault_code == 3'd1)));

    a_r11_lockout_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code == 3'd1) && en_in) |=> sleep_req);

    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (gate_off && !err_n));

endmodule

bind fault_supervisor fault_supervisor_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in      (en_in),
    .err_n      (err_n),
    .gate_off   (gate_off),
    .sleep_req  (sleep_req),
    .fault_code (fault_code)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;

    localparam int DB_OV = 6, DB_UV = 7, DB_VR = 5, DB_OC = 3, DB_OP = 4, DB_OT = 2;
    localparam int RSTM = 8, ARM = 10, SLP = 40, WAKE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0;
    logic ot_raw = 1'b0, ov_raw = 1'b0, oc_raw = 1'b0;
    logic vreg_uv_raw = 1'b0, vs_uv_raw = 1'b0, lvl_open_raw = 1'b0, sc_det = 1'b0;
    logic err_n, gate_off, sleep_req;
    logic [2:0] fault_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fault_supervisor #(
        .DB_OV_CYC (DB_OV), .DB_UVLO_CYC (DB_UV), .DB_VREG_CYC (DB_VR),
        .DB_OC_CYC (DB_OC), .DB_OPEN_CYC (DB_OP), .DB_OT_CYC (DB_OT),
        .RST_MIN_CYC (RSTM), .ARM_CYC (ARM), .SLEEP_CYC (SLP), .WAKE_CYC (WAKE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .en_in (en_in),
        .ot_raw (ot_raw), .ov_raw (ov_raw), .oc_raw (oc_raw),
        .vreg_uv_raw (vreg_uv_raw), .vs_uv_raw (vs_uv_raw),
        .lvl_open_raw (lvl_open_raw), .sc_det (sc_det),
        .err_n (err_n), .gate_off (gate_off), .sleep_req (sleep_req),
        .fault_code (fault_code)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input bit op, input bit vr, input bit ov,
                                    input bit ot, input bit oc);
        if (op) return 3;
        if (vr) return 4;
        if (ov) return 5;
        if (ot) return 6;
        if (oc) return 7;
        return 0;
    endfunction

    function automatic int exp_off(input bit op, input bit vr);
        return (op || vr) ? 1 : 0;
    endfunction

    task automatic check_run(input string tag, input int code);
        chk({tag, " code"}, int'(fault_code), code);
        chk({tag, " err_n"}, int'(err_n), (code == 0) ? 1 : 0);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1 reset state
        tick(3);
        chk("R1 sleep_req", int'(sleep_req), 1);
        chk("R1 gate_off", int'(gate_off), 1);
        chk("R1 err_n", int'(err_n), 0);
        chk("R1 code", int'(fault_code), 0);
        rst_n = 1'b1;
        tick(2);

        // R2 wake from sleep
        en_in = 1'b1;
        tick(1);
        chk("R2 sleep_req drop", int'(sleep_req), 0);
        tick(WAKE - 1);
        chk("R2 still waking err_n", int'(err_n), 0);
        chk("R2 still waking gate_off", int'(gate_off), 1);
        tick(1);
        chk("R2 running err_n", int'(err_n), 1);
        chk("R2 running gate_off", int'(gate_off), 0);

        // R3 debounce boundary, R4 over-current warning
        oc_raw = 1'b1;
        tick(DB_OC - 1);
        chk("R3 oc before window", int'(err_n), 1);
        tick(1);
        check_run("R4 oc", 7);
        chk("R4 oc gate_off", int'(gate_off), 0);
        oc_raw = 1'b0;
        tick(1);
        chk("R3 oc self clear", int'(err_n), 1);
        // R3 glitch shorter than window is ignored
        oc_raw = 1'b1;
        tick(DB_OC - 1);
        oc_raw = 1'b0;
        tick(1);
        chk("R3 short glitch ignored", int'(err_n), 1);

        // R4 over-temperature and over-voltage
        ot_raw = 1'b1; tick(DB_OT);
        check_run("R4 ot", 6);
        chk("R4 ot gate_off", int'(gate_off), 0);
        ov_raw = 1'b1; tick(DB_OV);
        check_run("R12 ov over ot", 5);
        ov_raw = 1'b0; ot_raw = 1'b0; tick(1);
        check_run("R4 ov ot clear", 0);

        // R5 regulator UV and open pin
        vreg_uv_raw = 1'b1; tick(DB_VR);
        check_run("R5 vreg", 4);
        chk("R5 vreg gate_off", int'(gate_off), 1);
        vreg_uv_raw = 1'b0; tick(1);
        chk("R5 vreg clear gate_off", int'(gate_off), 0);
        lvl_open_raw = 1'b1; tick(DB_OP);
        check_run("R5 open", 3);
        chk("R5 open gate_off", int'(gate_off), 1);
        lvl_open_raw = 1'b0; tick(1);
        chk("R5 open clear gate_off", int'(gate_off), 0);

        // R12 R13 random combinations
        for (int i = 0; i < 40; i++) begin
            bit b_op, b_vr, b_ov, b_ot, b_oc;
            b_op = 1'($urandom_range(0, 1)); b_vr = 1'($urandom_range(0, 1));
            b_ov = 1'($urandom_range(0, 1)); b_ot = 1'($urandom_range(0, 1));
            b_oc = 1'($urandom_range(0, 1));
            lvl_open_raw = b_op; vreg_uv_raw = b_vr; ov_raw = b_ov;
            ot_raw = b_ot; oc_raw = b_oc;
            tick(8);
            check_run("R12 random", exp_code(b_op, b_vr, b_ov, b_ot, b_oc));
            chk("R13 random gate_off", int'(gate_off), exp_off(b_op, b_vr));
            lvl_open_raw = 0; vreg_uv_raw = 0; ov_raw = 0; ot_raw = 0; oc_raw = 0;
            tick(2);
        end

        // R6 short latch
        sc_det = 1'b1; tick(1); sc_det = 1'b0;
        check_run("R6 short", 2);
        tick(5);
        chk("R6 short held", int'(fault_code), 2);
        chk("R6 short gate_off", int'(gate_off), 1);

        // R7 R8 R9 enable pulse at the tolerated width
        en_in = 1'b0;
        tick(1);
        chk("R7 err_n", int'(err_n), 0);
        chk("R7 gate_off", int'(gate_off), 1);
        tick(RSTM - 1);
        en_in = 1'b1;
        tick(ARM);
        chk("R9 arming gate_off", int'(gate_off), 1);
        chk("R9 arming err_n", int'(err_n), 0);
        tick(1);
        chk("R8 short kept", int'(fault_code), 2);

        // R8 one edge longer clears; open pin stays below short in priority
        lvl_open_raw = 1'b1; tick(DB_OP);
        chk("R12 short over open", int'(fault_code), 2);
        lvl_open_raw = 1'b0;
        en_in = 1'b0;
        tick(RSTM + 1);
        en_in = 1'b1;
        tick(ARM + 1);
        check_run("R8 short cleared", 0);
        chk("R9 resumed gate_off", int'(gate_off), 0);

        // R10 sleep after long enable low
        en_in = 1'b0;
        tick(SLP);
        chk("R10 not yet asleep", int'(sleep_req), 0);
        tick(1);
        chk("R10 asleep", int'(sleep_req), 1);
        en_in = 1'b1;
        tick(1);
        chk("R2 wake sleep_req", int'(sleep_req), 0);
        tick(WAKE - 1);
        chk("R2 wake pending", int'(err_n), 0);
        tick(1);
        chk("R2 wake done", int'(err_n), 1);

        // R11 supply lockout
        vs_uv_raw = 1'b1;
        tick(DB_UV);
        chk("R11 code", int'(fault_code), 1);
        chk("R11 err_n", int'(err_n), 0);
        tick(1);
        chk("R11 sleep_req", int'(sleep_req), 1);
        chk("R11 gate_off", int'(gate_off), 1);
        vs_uv_raw = 1'b0;
        tick(5);
        chk("R11 persists", int'(sleep_req), 1);
        en_in = 1'b0; tick(2);
        en_in = 1'b1; tick(ARM + 1);
        chk("R11 restart sleep_req", int'(sleep_req), 0);
        check_run("R11 restart", 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule